// File: doc/BRIEF.md
# Packed Lane Adder/Subtractor with Byte Flags

This block performs SIMD-style addition and subtraction on a 32-bit word. The word is split either into four 8-bit lanes or into two 16-bit lanes, and no carry or borrow crosses a lane boundary. In halfword mode, two exchange forms pair each halfword of the first operand with the opposite halfword of the second operand. One lane adds and the other subtracts.

Each lane can be treated as signed or unsigned. The result can be wrapped (modular), clamped to the lane's range (saturating), or halved after the arithmetic is done at full precision. Modular operations also record one greater-or-equal flag per byte in a small register. A later select operation uses that register to build a word byte by byte from its two operands.

An operation is presented with `in_valid` high for one cycle. Its result appears on `result` one clock later, with `result_valid` high for that cycle, and stays on `result` until the next operation.

Top module: `lane_addsub_unit`

## Requirements
- R1: A synchronous active-low reset clears `result` to 0, `result_valid` to 0 and `ge_flags` to 0000.
- R2: An operation accepted with `in_valid` high shows on `result` one cycle later with `result_valid` high for exactly that cycle. While `in_valid` is low, `result` holds its value and `result_valid` is low.
- R3: Opcode encoding: bits [1:0] give the kind (0 add, 1 subtract, 2 add-subtract with exchange, 3 subtract-add with exchange). Bit 2 selects two 16-bit lanes when set and four 8-bit lanes when clear. Bit 3 marks the lanes as signed. Bits [5:4] give the mode (0 modular, 1 saturating, 2 halving, 3 select). In modular mode each lane returns the low bits of its own sum or difference, with no carry between lanes.
- R4: In halfword mode, kind 2 gives top = a[31:16] + b[15:0] and bottom = a[15:0] - b[31:16]. Kind 3 gives top = a[31:16] - b[15:0] and bottom = a[15:0] + b[31:16]. In byte mode only bit 0 of the kind counts, so kind 2 acts as add and kind 3 as subtract.
- R5: Saturating mode clamps signed lanes to [-2^(n-1), 2^(n-1)-1] and unsigned lanes to [0, 2^n-1].
- R6: Halving mode returns the full-precision (n+1)-bit sum or difference shifted right by one. For unsigned lanes a negative difference keeps its sign bit, so 2 - 3 in a 16-bit lane gives 0xFFFF.
- R7: A modular operation loads `ge_flags`. A lane's flag is set when its exact signed result is non-negative (signed lanes), when the add carries out (unsigned add), or when a >= b (unsigned subtract). In halfword mode each lane's flag drives both of that lane's flag bits.
- R8: Saturating, halving and select operations, and idle cycles, leave `ge_flags` unchanged.
- R9: In select mode, result byte i is taken from `opnd_a` when flag bit i is set and from `opnd_b` otherwise. The flags written by a modular operation in the immediately preceding cycle are already in effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| op_code | input | 6 | Kind, lane width, signedness and mode |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| result | output | 32 | Registered result |
| result_valid | output | 1 | High one cycle after an accepted operation |
| ge_flags | output | 4 | Per-byte greater-or-equal flags |

## Verification
The bench targets lane boundaries where a wrong design is easy to spot. A carry leaking between lanes changes a neighbouring byte. Saturation at the most negative value would otherwise wrap to a large positive number. An unsigned halving subtract with a negative difference shows whether the sign bit is dropped, which would give 0x7FFF instead of 0xFFFF. It also checks the case where a 16-bit modular result wraps to a positive value while its flag must stay clear, since a design that took the flag from the wrapped bits would set it. Finally, it checks that saturating, halving and select operations leave the flags alone, and that a select issued right behind a flag update sees the new flags and not the stale ones.

// File: rtl/pa_pkg.sv
// Shared opcode types for the packed lane adder/subtractor.
// Assumes the opcode port carries an op_t, mode in the top bits.
package pa_pkg;

    typedef enum logic [1:0] {
        K_ADD = 2'd0,
        K_SUB = 2'd1,
        K_ASX = 2'd2,
        K_SAX = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        M_MOD  = 2'd0,
        M_SAT  = 2'd1,
        M_HALF = 2'd2,
        M_SEL  = 2'd3
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  sgn;
        logic  wide;
        kind_e kind;
    } op_t;

    localparam int OP_W = $bits(op_t);

endpackage

// File: rtl/pa_lane.sv
// One arithmetic lane of W bits: add or subtract, then wrap, clamp or halve.
// Assumes a combinational context; the caller registers the outputs.
module pa_lane
    import pa_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         sub,
    input  logic         sgn,
    input  mode_e        mode,
    output logic [W-1:0] res,
    output logic         ge
);

    localparam int EW = W + 1;

    logic [EW-1:0] ex, ey, full;
    logic [W-1:0]  wrap_v, half_v, sat_v;
    logic          ovf_s;

    // Extend both inputs by one bit and form the exact result.
    always_comb begin
        ex   = {sgn & x[W-1], x};
        ey   = {sgn & y[W-1], y};
        full = sub ? (ex - ey) : (ex + ey);
    end

    // Derive the three result forms from the exact value.
    always_comb begin
        wrap_v = full[W-1:0];
        half_v = full[EW-1:1];
        ovf_s  = full[W] ^ full[W-1];
        if (sgn) begin
            if (ovf_s)
                sat_v = full[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
            else
                sat_v = wrap_v;
        end else begin
            if (full[W])
                sat_v = sub ? {W{1'b0}} : {W{1'b1}};
            else
                sat_v = wrap_v;
        end
    end

    // Pick the form named by the mode.
    always_comb begin
        case (mode)
            M_SAT:   res = sat_v;
            M_HALF:  res = half_v;
            default: res = wrap_v;
        endcase
    end

    // Greater-or-equal flag from the exact result.
    always_comb begin
        if (sgn)
            ge = ~full[W];
        else
            ge = sub ? ~full[W] : full[W];
    end

    // Unsigned clamps keep order with the first operand (R5).
    always_comb begin
        if (mode == M_SAT && !sgn && !sub)
            p_usat_add_floor_r5: assert (res >= x);
        if (mode == M_SAT && !sgn && sub)
            p_usat_sub_ceil_r5: assert (res <= x);
    end

endmodule

// File: rtl/pa_ge_flags.sv
// Per-byte greater-or-equal flag register.
// Assumes upd is high only for an accepted modular operation.
module pa_ge_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd,
    input  logic [N-1:0] nxt,
    output logic [N-1:0] q
);

    // Load new flags on update, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (upd)
            q <= nxt;
    end

    p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(q));

    p_flags_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (q == $past(nxt)));

endmodule

// File: rtl/pa_byte_select.sv
// Chooses each byte from a or b according to a per-byte flag.
// Assumes the flag vector has one bit per byte of the data word.
module pa_byte_select #(
    parameter int BW = 8,
    parameter int N  = 4
) (
    input  logic [BW*N-1:0] a,
    input  logic [BW*N-1:0] b,
    input  logic [N-1:0]    sel,
    output logic [BW*N-1:0] y
);

    for (genvar i = 0; i < N; i++) begin : g_byte
        // Per-byte two-way mux.
        always_comb y[i*BW +: BW] = sel[i] ? a[i*BW +: BW] : b[i*BW +: BW];
    end

endmodule

// File: rtl/lane_addsub_unit.sv
// Packed add/subtract unit: byte or halfword lanes, exchange forms,
// modular/saturating/halving results, byte flags and flag-driven select.
// Assumes LANES is even so halfword lanes pair up for exchange.
module lane_addsub_unit
    import pa_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int LANES  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [OP_W-1:0]         op_code,
    input  logic [LANE_W*LANES-1:0] opnd_a,
    input  logic [LANE_W*LANES-1:0] opnd_b,
    output logic [LANE_W*LANES-1:0] result,
    output logic                    result_valid,
    output logic [LANES-1:0]        ge_flags
);

    localparam int DATA_W = LANE_W * LANES;
    localparam int HALF_W = 2 * LANE_W;
    localparam int HALVES = LANES / 2;

    op_t               op;
    logic [DATA_W-1:0] byte_res, half_res, arith_res, sel_res, next_res;
    logic [LANES-1:0]  byte_ge, flag_nxt;
    logic [HALVES-1:0] half_ge;
    logic              flag_upd;

    // Decode the opcode bits into fields.
    always_comb op = op_t'(op_code);

    for (genvar i = 0; i < LANES; i++) begin : g_byte_lane
        pa_lane #(.W(LANE_W)) u_lane (
            .x    (opnd_a[i*LANE_W +: LANE_W]),
            .y    (opnd_b[i*LANE_W +: LANE_W]),
            .sub  (op.kind[0]),
            .sgn  (op.sgn),
            .mode (op.mode),
            .res  (byte_res[i*LANE_W +: LANE_W]),
            .ge   (byte_ge[i])
        );
    end

    for (genvar h = 0; h < HALVES; h++) begin : g_half_lane
        localparam bit ODD  = (h % 2) == 1;
        localparam int PART = ODD ? h - 1 : h + 1;
        logic [HALF_W-1:0] y_sel;
        logic              sub_h;

        // Route the second operand and pick add or subtract per lane.
        always_comb begin
            if (op.kind[1]) begin
                y_sel = opnd_b[PART*HALF_W +: HALF_W];
                sub_h = op.kind[0] ? ODD : !ODD;
            end else begin
                y_sel = opnd_b[h*HALF_W +: HALF_W];
                sub_h = op.kind[0];
            end
        end

        pa_lane #(.W(HALF_W)) u_lane (
            .x    (opnd_a[h*HALF_W +: HALF_W]),
            .y    (y_sel),
            .sub  (sub_h),
            .sgn  (op.sgn),
            .mode (op.mode),
            .res  (half_res[h*HALF_W +: HALF_W]),
            .ge   (half_ge[h])
        );

        // Each halfword flag covers both of its bytes.
        always_comb flag_nxt_wide[2*h +: 2] = {2{half_ge[h]}};
    end

    logic [LANES-1:0] flag_nxt_wide;

    // Choose lane layout for the result and the flags.
    always_comb begin
        arith_res = op.wide ? half_res : byte_res;
        flag_nxt  = op.wide ? flag_nxt_wide : byte_ge;
        flag_upd  = in_valid && (op.mode == M_MOD);
    end

    pa_ge_flags #(.N(LANES)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (flag_upd),
        .nxt   (flag_nxt),
        .q     (ge_flags)
    );

    pa_byte_select #(.BW(LANE_W), .N(LANES)) u_sel (
        .a   (opnd_a),
        .b   (opnd_b),
        .sel (ge_flags),
        .y   (sel_res)
    );

    // Final mux between arithmetic and select.
    always_comb next_res = (op.mode == M_SEL) ? sel_res : arith_res;

    // Register the result and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result       <= '0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= in_valid;
            if (in_valid)
                result <= next_res;
        end
    end

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> result_valid);

    p_result_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!result_valid && $stable(result)));

    for (genvar i = 0; i < LANES; i++) begin : g_sel_chk
        p_select_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && op.mode == M_SEL) |=>
            (result[i*LANE_W +: LANE_W] ==
             ($past(ge_flags[i]) ? $past(opnd_a[i*LANE_W +: LANE_W])
                                 : $past(opnd_b[i*LANE_W +: LANE_W]))));
    end

    for (genvar h = 0; h < HALVES; h++) begin : g_pair_chk
        p_wide_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_upd && op.wide) |=> (ge_flags[2*h] == ge_flags[2*h+1]));
    end

endmodule

// File: tb/lane_addsub_unit_bench.sv
// Self-checking bench: vector table walk, then directed flag/reset tests.
module lane_addsub_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [5:0]  op_code = '0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic [31:0] result;
    logic        result_valid;
    logic [3:0]  ge_flags;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lane_addsub_unit u_lane_addsub_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .op_code      (op_code),
        .opnd_a       (opnd_a),
        .opnd_b       (opnd_b),
        .result       (result),
        .result_valid (result_valid),
        .ge_flags     (ge_flags)
    );

    // {opcode, a, b, expected}
    localparam int NV = 25;
    localparam logic [101:0] VEC [NV] = '{
        {6'h08, 32'h87858381, 32'h08060402, 32'h8F8B8783},
        {6'h09, 32'h8F8B8783, 32'h08060402, 32'h87858381},
        {6'h28, 32'h07050302, 32'h08060402, 32'h07050302},
        {6'h29, 32'h8F8B8783, 32'h08060402, 32'hC3C2C1C0},
        {6'h18, 32'h8085837F, 32'hFF060402, 32'h808B877F},
        {6'h19, 32'h808B8783, 32'h08060402, 32'h80858381},
        {6'h00, 32'h07050301, 32'h08060402, 32'h0F0B0703},
        {6'h21, 32'h0F0B0703, 32'h08060402, 32'h03020100},
        {6'h10, 32'hFF050301, 32'h08060402, 32'hFF0B0703},
        {6'h11, 32'h080B0702, 32'h0F060408, 32'h00050300},
        {6'h0C, 32'h80038001, 32'h00040002, 32'h80078003},
        {6'h0E, 32'h80078003, 32'h00040002, 32'h80097FFF},
        {6'h0F, 32'h80038007, 32'h00020004, 32'h7FFF8009},
        {6'h2C, 32'h80038001, 32'h00040002, 32'hC003C001},
        {6'h2E, 32'h80078003, 32'h00040002, 32'hC004BFFF},
        {6'h1C, 32'h80038000, 32'h00048002, 32'h80078000},
        {6'h1E, 32'h80078003, 32'h00040002, 32'h80098000},
        {6'h1F, 32'h80038007, 32'h00020004, 32'h80008009},
        {6'h26, 32'h80078003, 32'h00040002, 32'h40043FFF},
        {6'h27, 32'h80038007, 32'h00020004, 32'h3FFF4004},
        {6'h16, 32'hFFF80003, 32'h00040009, 32'hFFFF0000},
        {6'h17, 32'h0003FFF8, 32'h00090004, 32'h0000FFFF},
        {6'h25, 32'h00020006, 32'h00030004, 32'hFFFF0001},
        {6'h02, 32'h01020304, 32'h10101010, 32'h11121314},
        {6'h15, 32'h00020006, 32'h00030004, 32'h00000002}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One-cycle operation; returns at the negedge where the result is visible.
    task automatic do_op(input logic [5:0] op, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        op_code  = op;
        opnd_a   = a;
        opnd_b   = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 result after reset", result, 32'h0);
        chk("R1 valid after reset", {31'h0, result_valid}, 32'h0);
        chk("R1 flags after reset", {28'h0, ge_flags}, 32'h0);

        // Table walk over R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            do_op(VEC[i][101:96], VEC[i][95:64], VEC[i][63:32]);
            chk($sformatf("R3 R4 R5 R6 vector %0d", i), result, VEC[i][31:0]);
        end

        // R2 strobe and hold
        do_op(6'h00, 32'h01010101, 32'h01010101);
        chk("R2 valid one cycle after", {31'h0, result_valid}, 32'h1);
        opnd_a = 32'hDEADBEEF;
        repeat (3) @(negedge clk);
        chk("R2 result holds", result, 32'h02020202);
        chk("R2 valid drops", {31'h0, result_valid}, 32'h0);

        // R7 signed byte flags, then R9 select
        do_op(6'h08, 32'h80808080, 32'h0);
        chk("R7 signed add all negative", {28'h0, ge_flags}, 32'h0);
        do_op(6'h08, 32'h80808000, 32'h0);
        chk("R7 signed add lane0 nonneg", {28'h0, ge_flags}, 32'h1);
        do_op(6'h30, 32'h33221100, 32'h77665544);
        chk("R9 select flags 0001", result, 32'h77665500);
        do_op(6'h08, 32'h80800080, 32'h0);
        do_op(6'h30, 32'h33221100, 32'h77665544);
        chk("R9 select flags 0010", result, 32'h77661144);

        // R7 unsigned add carry and unsigned subtract no-borrow
        do_op(6'h00, 32'hFF00FF00, 32'h01000100);
        chk("R7 unsigned add carry", {28'h0, ge_flags}, 32'hA);
        do_op(6'h01, 32'h05050505, 32'h06050406);
        chk("R7 unsigned sub no borrow", {28'h0, ge_flags}, 32'h6);

        // R7 halfword flags from exact result, modular wrap positive
        do_op(6'h0D, 32'h00058000, 32'h00020001);
        chk("R7 halfword sub result", result, 32'h00037FFF);
        chk("R7 halfword flag pairs", {28'h0, ge_flags}, 32'hC);

        // R8 saturating, halving, select and idle keep flags
        do_op(6'h1C, 32'h80008000, 32'h80008000);
        chk("R8 saturating leaves flags", {28'h0, ge_flags}, 32'hC);
        do_op(6'h28, 32'h80808080, 32'h00000000);
        chk("R8 halving leaves flags", {28'h0, ge_flags}, 32'hC);
        do_op(6'h30, 32'h33221100, 32'h77665544);
        chk("R8 select leaves flags", {28'h0, ge_flags}, 32'hC);
        chk("R9 select flags 1100", result, 32'h33225544);
        repeat (4) @(negedge clk);
        chk("R8 idle leaves flags", {28'h0, ge_flags}, 32'hC);

        // R9 back-to-back: select sees flags written the cycle before
        @(negedge clk);
        in_valid = 1'b1; op_code = 6'h08; opnd_a = 32'h80808000; opnd_b = 32'h0;
        @(negedge clk);
        chk("R3 back-to-back first result", result, 32'h80808000);
        op_code = 6'h30; opnd_a = 32'h33221100; opnd_b = 32'h77665544;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9 select uses fresh flags", result, 32'h77665500);

        // R1 reset in mid-run
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid reset result", result, 32'h0);
        chk("R1 mid reset flags", {28'h0, ge_flags}, 32'h0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule